// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block connects one PS/2 keyboard or mouse to a register bus. It watches the open-drain clock and data lines and assembles each 11-bit frame the device sends. The data byte waits in a one-byte receive register until software reads it. Parity errors and lost bytes are flagged beside the byte. For the other direction, software writes a byte to a one-byte transmit register. The block then runs the host request-to-send sequence: it holds the clock low for a programmable number of bus clocks, pulls data low, releases the clock, and shifts the byte out on the edges the device generates. At the end it checks the device's acknowledge.

Software turns the receiver and transmitter on and off with separate write-one strobes. A software reset strobe returns the block to its idle state. Six status flags feed a level interrupt through a mask. The mask is set through one address and cleared through another, and can be read back at a third. The interrupt output is high while any masked-in flag is set.

Top module: `ps2h_ctrl`

## Requirements
- R1: After reset, the status register (0x10) reads 0x0003: TXRDY (bit 0) and TXEMPTY (bit 1) are set, and RXRDY (bit 4), OVRUN (bit 5), NACK (bit 8) and PARITY (bit 9) are clear. The mask (0x1C) reads 0, the interrupt is low, the prescale register reads 100, and neither line is driven.
- R2: The prescale register at 0x24 is 12 bits wide. A write keeps bits 11:0 and reads back with the upper bits zero.
- R3: A control write (0x00) with bit 0 set turns the receiver on and with bit 1 set turns it off. Bit 8 turns the transmitter on and bit 9 turns it off. When a write sets both bits of a pair, the off bit wins. A disabled receiver ignores device frames, and a disabled transmitter never drives the clock line.
- R4: A valid frame has a start bit of 0, eight data bits LSB first, an odd parity bit and a stop bit of 1, each sampled on a falling clock edge. It places the byte in bits 7:0 of the receive register (0x04) and sets RXRDY.
- R5: A frame whose parity bit makes the total count of ones even still delivers its byte, and it sets PARITY.
- R6: A frame that completes while RXRDY is still set sets OVRUN, and the receive register then holds the newer byte.
- R7: A read of the receive register clears RXRDY, OVRUN and PARITY.
- R8: A frame whose stop bit is 0 is dropped. A partial frame is also abandoned when no falling clock edge arrives for WDOG_PERIODS prescale periods (8 by default). The next frame is then received cleanly.
- R9: Writing 1s to 0x14 sets mask bits and writing 1s to 0x18 clears them. Only bits 0, 1, 4, 5, 8 and 9 exist. The interrupt is high while any status bit and its mask bit are both set.
- R10: A write to the transmit register (0x08) starts a transfer. The clock is held low for max(prescale, 4) bus clocks before data is pulled low. The clock is then released, and the data bits (LSB first), odd parity and a released stop bit are presented after successive falling edges.
- R11: TXRDY is clear while a written byte waits to start. TXEMPTY is clear from the write until the acknowledge has been sampled. A byte written while the transmitter is off waits, and it is sent once the transmitter is turned on.
- R12: NACK is set when the data line is high at the eleventh falling edge of a transfer. The next write to the transmit register clears it.
- R13: Setting control bit 15 returns every flag, the mask, the enables and both hold registers to the R1 state, but the prescale value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the address |
| ps2_clk_i | input | 1 | Sensed level of the PS/2 clock line |
| ps2_dat_i | input | 1 | Sensed level of the PS/2 data line |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the data line low |
| irq | output | 1 | Level interrupt |

## Verification
Register writes take effect at the rising edge that samples the strobe. Read data and the interrupt follow from registered state in the same cycle, so the bench samples them on the falling edge right after the write. A device frame reaches RXRDY four bus clocks after the clock line falls for the stop bit (two synchroniser stages, the edge flop, and the receiver output register). The bench reads only after half a device clock period, 15 bus clocks, has passed. On the transmit side, the clock is pulled low two edges after the write, and the bench counts every cycle in which the clock is held but data is not yet pulled, to compare the hold length exactly. The bench checks completion of the acknowledge only after its device model has released the eleventh clock pulse.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;

    localparam int ADDR_W = 6;
    localparam int BUS_W  = 16;

    // register offsets seen by software
    localparam logic [ADDR_W-1:0] A_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] A_RXH  = 6'h04;
    localparam logic [ADDR_W-1:0] A_TXH  = 6'h08;
    localparam logic [ADDR_W-1:0] A_STAT = 6'h10;
    localparam logic [ADDR_W-1:0] A_IEN  = 6'h14;
    localparam logic [ADDR_W-1:0] A_IDIS = 6'h18;
    localparam logic [ADDR_W-1:0] A_IMSK = 6'h1C;
    localparam logic [ADDR_W-1:0] A_PSC  = 6'h24;

    // flag positions shared by status, enable, disable and mask
    localparam int B_TXRDY   = 0;
    localparam int B_TXEMPTY = 1;
    localparam int B_RXRDY   = 4;
    localparam int B_OVR     = 5;
    localparam int B_NACK    = 8;
    localparam int B_PAR     = 9;
    localparam logic [BUS_W-1:0] FLAG_BITS = 16'h0333;

    // control strobes
    localparam int C_RXON  = 0;
    localparam int C_RXOFF = 1;
    localparam int C_TXON  = 8;
    localparam int C_TXOFF = 9;
    localparam int C_RST   = 15;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HOLD,
        TX_REQ,
        TX_SHIFT
    } tx_state_e;

endpackage

// File: rtl/ps2h_sync.sv
module ps2h_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign level_o = sh_q[STAGES-1];

endmodule

// File: rtl/ps2h_rx.sv
module ps2h_rx #(
    parameter int PSC_W        = 12,
    parameter int WDOG_PERIODS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             fall_i,
    input  logic             dat_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             valid_o,
    output logic [7:0]       byte_o,
    output logic             perr_o
);

    localparam int PER_W = $clog2(WDOG_PERIODS + 1);
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(WDOG_PERIODS - 1);
    localparam logic [3:0] POS_PAR  = 4'd9;
    localparam logic [3:0] POS_STOP = 4'd10;

    typedef struct packed {
        logic [3:0]       pos;
        logic [7:0]       sh;
        logic             perr;
        logic             valid;
        logic [PSC_W-1:0] tick;
        logic [PER_W-1:0] per;
    } rx_s;

    rx_s r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (clr_i) begin
            r_d.pos  = '0;
            r_d.tick = '0;
            r_d.per  = '0;
        end else if (fall_i) begin
            r_d.tick = '0;
            r_d.per  = '0;
            if (r_q.pos == 4'd0) begin
                if (!dat_i) r_d.pos = 4'd1;
            end else if (r_q.pos < POS_PAR) begin
                r_d.sh  = {dat_i, r_q.sh[7:1]};
                r_d.pos = r_q.pos + 4'd1;
            end else if (r_q.pos == POS_PAR) begin
                r_d.perr = ~(^{r_q.sh, dat_i});
                r_d.pos  = POS_STOP;
            end else begin
                r_d.valid = dat_i;
                r_d.pos   = '0;
            end
        end else if (r_q.pos != 4'd0) begin
            if (({1'b0, r_q.tick} + 1'b1) >= {1'b0, psc_i}) begin
                r_d.tick = '0;
                if (r_q.per == PER_LAST) begin
                    r_d.per = '0;
                    r_d.pos = '0;
                end else begin
                    r_d.per = r_q.per + 1'b1;
                end
            end else begin
                r_d.tick = r_q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign valid_o = r_q.valid;
    assign byte_o  = r_q.sh;
    assign perr_o  = r_q.perr;

    assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pos <= POS_STOP);

    assert_valid_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |-> ($past(r_q.pos) == POS_STOP && $past(fall_i)));

endmodule

// File: rtl/ps2h_tx.sv
module ps2h_tx
    import ps2h_pkg::*;
#(
    parameter int PSC_W    = 12,
    parameter int MIN_HOLD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             start_i,
    input  logic [7:0]       byte_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic             fall_i,
    input  logic             dat_i,
    output logic             clk_oe_o,
    output logic             dat_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             nack_o
);

    localparam logic [PSC_W-1:0] HOLD_MIN = PSC_W'(MIN_HOLD);
    localparam logic [3:0]       IDX_ACK  = 4'd10;

    typedef struct packed {
        tx_state_e        st;
        logic [PSC_W-1:0] cnt;
        logic [9:0]       sh;
        logic [3:0]       idx;
        logic             clk_oe;
        logic             dat_oe;
        logic             done;
        logic             nack;
    } tx_s;

    tx_s t_d, t_q;
    logic [PSC_W-1:0] hold_w;

    assign hold_w = (psc_i > HOLD_MIN) ? psc_i : HOLD_MIN;

    always_comb begin
        t_d      = t_q;
        t_d.done = 1'b0;
        if (clr_i) begin
            t_d.st     = TX_IDLE;
            t_d.cnt    = '0;
            t_d.idx    = '0;
            t_d.clk_oe = 1'b0;
            t_d.dat_oe = 1'b0;
        end else begin
            unique case (t_q.st)
                TX_IDLE: if (start_i) begin
                    t_d.st     = TX_HOLD;
                    t_d.cnt    = '0;
                    t_d.idx    = '0;
                    t_d.sh     = {1'b1, ~(^byte_i), byte_i};
                    t_d.clk_oe = 1'b1;
                    t_d.dat_oe = 1'b0;
                end
                TX_HOLD: begin
                    if (t_q.cnt == hold_w - 1'b1) begin
                        t_d.st     = TX_REQ;
                        t_d.dat_oe = 1'b1;
                    end else begin
                        t_d.cnt = t_q.cnt + 1'b1;
                    end
                end
                TX_REQ: begin
                    t_d.st     = TX_SHIFT;
                    t_d.clk_oe = 1'b0;
                end
                TX_SHIFT: if (fall_i) begin
                    if (t_q.idx == IDX_ACK) begin
                        t_d.nack   = dat_i;
                        t_d.done   = 1'b1;
                        t_d.st     = TX_IDLE;
                        t_d.dat_oe = 1'b0;
                    end else begin
                        t_d.dat_oe = ~t_q.sh[0];
                        t_d.sh     = {1'b1, t_q.sh[9:1]};
                        t_d.idx    = t_q.idx + 4'd1;
                    end
                end
                default: t_d.st = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q    <= '0;
            t_q.st <= TX_IDLE;
        end else begin
            t_q <= t_d;
        end
    end

    assign clk_oe_o = t_q.clk_oe;
    assign dat_oe_o = t_q.dat_oe;
    assign busy_o   = (t_q.st != TX_IDLE);
    assign done_o   = t_q.done;
    assign nack_o   = t_q.nack;

    assert_inhibit_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.clk_oe) |-> $past(start_i));

    assert_request_then_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.clk_oe && t_q.dat_oe) |=> (!t_q.clk_oe && t_q.dat_oe));

    assert_done_on_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.done |-> $past(fall_i));

endmodule

// File: rtl/ps2h_ctrl.sv
module ps2h_ctrl
    import ps2h_pkg::*;
#(
    parameter int              PSC_W        = 12,
    parameter logic [PSC_W-1:0] PSC_RST     = 12'd100,
    parameter int              WDOG_PERIODS = 8,
    parameter int              SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ps2_clk_i,
    input  logic              ps2_dat_i,
    output logic              ps2_clk_oe,
    output logic              ps2_dat_oe,
    output logic              irq
);

    localparam int MIN_HOLD = SYNC_STAGES + 2;

    typedef struct packed {
        logic             rx_en;
        logic             tx_en;
        logic [7:0]       rxh;
        logic             rxrdy;
        logic             ovr;
        logic             perr;
        logic             nack;
        logic [7:0]       thr;
        logic             thr_full;
        logic [BUS_W-1:0] imr;
        logic [PSC_W-1:0] psc;
        logic             clk_prev;
    } top_s;

    function automatic top_s top_reset();
        top_s v;
        v          = '0;
        v.psc      = PSC_RST;
        v.clk_prev = 1'b1;
        return v;
    endfunction

    top_s s_d, s_q;

    logic [1:0] line_w, lvl_w;
    logic       fall_w;
    logic       rx_valid, rx_perr;
    logic [7:0] rx_byte;
    logic       tx_busy, tx_done, tx_nack, tx_start;
    logic       soft_w, rhr_rd;
    logic [BUS_W-1:0] stat_w;

    assign line_w = {ps2_dat_i, ps2_clk_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        ps2h_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (line_w[g]),
            .level_o(lvl_w[g])
        );
    end

    assign fall_w   = s_q.clk_prev & ~lvl_w[0];
    assign soft_w   = bus_wr && (bus_addr == A_CTRL) && bus_wdata[C_RST];
    assign rhr_rd   = bus_rd && (bus_addr == A_RXH);
    assign tx_start = s_q.thr_full && s_q.tx_en && !tx_busy;

    ps2h_rx #(.PSC_W(PSC_W), .WDOG_PERIODS(WDOG_PERIODS)) rx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (soft_w || !s_q.rx_en || tx_busy),
        .fall_i (fall_w),
        .dat_i  (lvl_w[1]),
        .psc_i  (s_q.psc),
        .valid_o(rx_valid),
        .byte_o (rx_byte),
        .perr_o (rx_perr)
    );

    ps2h_tx #(.PSC_W(PSC_W), .MIN_HOLD(MIN_HOLD)) tx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (soft_w || !s_q.tx_en),
        .start_i (tx_start),
        .byte_i  (s_q.thr),
        .psc_i   (s_q.psc),
        .fall_i  (fall_w),
        .dat_i   (lvl_w[1]),
        .clk_oe_o(ps2_clk_oe),
        .dat_oe_o(ps2_dat_oe),
        .busy_o  (tx_busy),
        .done_o  (tx_done),
        .nack_o  (tx_nack)
    );

    always_comb begin
        stat_w            = '0;
        stat_w[B_TXRDY]   = ~s_q.thr_full;
        stat_w[B_TXEMPTY] = ~s_q.thr_full & ~tx_busy;
        stat_w[B_RXRDY]   = s_q.rxrdy;
        stat_w[B_OVR]     = s_q.ovr;
        stat_w[B_NACK]    = s_q.nack;
        stat_w[B_PAR]     = s_q.perr;
    end

    always_comb begin
        s_d          = s_q;
        s_d.clk_prev = lvl_w[0];

        if (rx_valid) begin
            s_d.ovr   = s_q.rxrdy & ~rhr_rd;
            s_d.rxrdy = 1'b1;
            s_d.perr  = rx_perr;
            s_d.rxh   = rx_byte;
        end else if (rhr_rd) begin
            s_d.rxrdy = 1'b0;
            s_d.ovr   = 1'b0;
            s_d.perr  = 1'b0;
        end

        if (tx_start) s_d.thr_full = 1'b0;
        if (tx_done)  s_d.nack     = tx_nack;

        if (bus_wr) begin
            unique case (bus_addr)
                A_CTRL: begin
                    if (bus_wdata[C_RXON])  s_d.rx_en = 1'b1;
                    if (bus_wdata[C_RXOFF]) s_d.rx_en = 1'b0;
                    if (bus_wdata[C_TXON])  s_d.tx_en = 1'b1;
                    if (bus_wdata[C_TXOFF]) s_d.tx_en = 1'b0;
                end
                A_TXH: begin
                    s_d.thr      = bus_wdata[7:0];
                    s_d.thr_full = 1'b1;
                    s_d.nack     = 1'b0;
                end
                A_IEN:  s_d.imr = s_q.imr | (bus_wdata & FLAG_BITS);
                A_IDIS: s_d.imr = s_q.imr & ~bus_wdata;
                A_PSC:  s_d.psc = bus_wdata[PSC_W-1:0];
                default: ;
            endcase
        end

        if (soft_w) begin
            s_d          = top_reset();
            s_d.psc      = s_q.psc;
            s_d.clk_prev = lvl_w[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= top_reset();
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_RXH:  bus_rdata[7:0]       = s_q.rxh;
            A_STAT: bus_rdata            = stat_w;
            A_IMSK: bus_rdata            = s_q.imr;
            A_PSC:  bus_rdata[PSC_W-1:0] = s_q.psc;
            default: ;
        endcase
    end

    assign irq = |(stat_w & s_q.imr);

    assert_ovr_needs_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovr |-> s_q.rxrdy);

    assert_perr_needs_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.perr |-> s_q.rxrdy);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rhr_rd && !rx_valid) |=> (!s_q.rxrdy && !s_q.ovr && !s_q.perr));

    assert_mask_bits_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.imr & ~FLAG_BITS) == '0);

    assert_enable_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_IEN) |=>
        ((s_q.imr & $past(bus_wdata & FLAG_BITS)) == $past(bus_wdata & FLAG_BITS)));

    assert_tx_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ps2_clk_oe) |-> $past(s_q.tx_en));

endmodule

// File: tb/ps2h_ctrl_tb_top.sv
module ps2h_ctrl_tb_top;
    import ps2h_pkg::*;

    localparam int HALF     = 15;
    localparam int EXP_HOLD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic clk_oe, dat_oe, irq;
    logic dev_clk_low = 1'b0, dev_dat_low = 1'b0, dev_nack = 1'b0;
    logic clk_line, dat_line;

    int checks = 0, fails = 0, tx_seen = 0;
    logic [7:0] tx_exp[$];

    always #10 clk = ~clk;

    assign clk_line = ~(clk_oe | dev_clk_low);
    assign dat_line = ~(dat_oe | dev_dat_low);

    ps2h_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ps2_clk_i(clk_line), .ps2_dat_i(dat_line),
        .ps2_clk_oe(clk_oe), .ps2_dat_oe(dat_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_reg(input string req, input logic [5:0] a, input logic [15:0] exp);
        logic [15:0] v;
        bus_read(a, v);
        chk(req, {16'h0, v}, {16'h0, exp});
    endtask

    task automatic dev_bit(input logic b);
        dev_dat_low = ~b;
        repeat (HALF) @(negedge clk);
        dev_clk_low = 1'b1;
        repeat (HALF) @(negedge clk);
        dev_clk_low = 1'b0;
    endtask

    task automatic dev_send(input logic [7:0] b, input logic bad_par,
                            input logic bad_stop, input int nbits);
        logic [10:0] fr;
        fr = {~bad_stop, (~(^b)) ^ bad_par, b, 1'b0};
        for (int i = 0; i < nbits; i++) dev_bit(fr[i]);
        dev_dat_low = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    // scoreboard driver: expected byte queued before the write
    task automatic send_host(input logic [7:0] b);
        tx_exp.push_back(b);
        bus_write(A_TXH, {8'h00, b});
    endtask

    task automatic wait_tx(input int n);
        for (int i = 0; i < 5000 && tx_seen < n; i++) @(negedge clk);
        chk("R10 transfer completed", tx_seen, n);
    endtask

    // monitor: device side of a host transfer, compares against the queue
    initial begin
        int hold_cnt;
        logic [9:0] got;
        logic [7:0] exp;
        forever begin
            @(negedge clk iff clk_oe);
            hold_cnt = 0;
            while (clk_oe && !dat_oe) begin hold_cnt++; @(negedge clk); end
            while (clk_oe) @(negedge clk);
            chk("R10 start bit low", {31'h0, dat_line}, 32'h0);
            for (int i = 0; i < 10; i++) begin
                repeat (HALF) @(negedge clk);
                dev_clk_low = 1'b1;
                repeat (HALF) @(negedge clk);
                got[i] = dat_line;
                dev_clk_low = 1'b0;
            end
            if (!dev_nack) dev_dat_low = 1'b1;
            repeat (HALF) @(negedge clk);
            dev_clk_low = 1'b1;
            repeat (HALF) @(negedge clk);
            dev_clk_low = 1'b0;
            dev_dat_low = 1'b0;
            if (tx_exp.size() == 0) begin
                chk("R10 unexpected transfer", 32'h1, 32'h0);
            end else begin
                exp = tx_exp.pop_front();
                chk("R10 data byte", {24'h0, got[7:0]}, {24'h0, exp});
                chk("R10 odd parity", {31'h0, got[8]}, {31'h0, ~(^exp)});
                chk("R10 stop released", {31'h0, got[9]}, 32'h1);
                chk("R10 inhibit length", hold_cnt, EXP_HOLD);
            end
            tx_seen++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_reg("R1 status after reset", A_STAT, 16'h0003);
        chk_reg("R1 mask after reset", A_IMSK, 16'h0000);
        chk_reg("R1 prescale after reset", A_PSC, 16'd100);
        chk("R1 irq low", {31'h0, irq}, 32'h0);
        chk("R1 lines released", {30'h0, clk_oe, dat_oe}, 32'h0);

        // R2 prescale width
        bus_write(A_PSC, 16'hF014);
        chk_reg("R2 prescale keeps 12 bits", A_PSC, 16'h0014);

        // R3 receiver off ignores frames
        dev_send(8'h42, 1'b0, 1'b0, 11);
        chk_reg("R3 disabled receiver ignores frame", A_STAT, 16'h0003);

        bus_write(A_CTRL, 16'h0101);

        // R9 mask set/clear
        bus_write(A_IEN, 16'hFFFF);
        chk_reg("R9 only flag bits in mask", A_IMSK, 16'h0333);
        chk("R9 irq from TXRDY", {31'h0, irq}, 32'h1);
        bus_write(A_IDIS, 16'hFFFF);
        chk_reg("R9 disable clears mask", A_IMSK, 16'h0000);
        chk("R9 irq low when masked", {31'h0, irq}, 32'h0);

        // R4 plain frame
        dev_send(8'hA5, 1'b0, 1'b0, 11);
        chk_reg("R4 RXRDY set", A_STAT, 16'h0013);
        chk("R9 irq stays low while RXRDY masked", {31'h0, irq}, 32'h0);
        chk_reg("R4 byte A5", A_RXH, 16'h00A5);
        chk_reg("R7 read clears RXRDY", A_STAT, 16'h0003);

        // R9 interrupt on RXRDY
        bus_write(A_IEN, 16'h0010);
        dev_send(8'h3C, 1'b0, 1'b0, 11);
        chk("R9 irq on RXRDY", {31'h0, irq}, 32'h1);
        bus_write(A_IDIS, 16'h0010);
        chk("R9 irq drops after disable", {31'h0, irq}, 32'h0);
        bus_write(A_IEN, 16'h0010);
        chk("R9 irq returns after enable", {31'h0, irq}, 32'h1);
        chk_reg("R4 byte 3C", A_RXH, 16'h003C);
        chk("R7 irq low after read", {31'h0, irq}, 32'h0);
        bus_write(A_IDIS, 16'h0010);

        // R5 parity error
        dev_send(8'h5A, 1'b1, 1'b0, 11);
        chk_reg("R5 PARITY with RXRDY", A_STAT, 16'h0213);
        chk_reg("R5 byte still delivered", A_RXH, 16'h005A);
        chk_reg("R7 read clears PARITY", A_STAT, 16'h0003);

        // R6 overrun
        dev_send(8'h11, 1'b0, 1'b0, 11);
        dev_send(8'h22, 1'b0, 1'b0, 11);
        chk_reg("R6 OVRUN set", A_STAT, 16'h0033);
        chk_reg("R6 newest byte kept", A_RXH, 16'h0022);
        chk_reg("R7 read clears OVRUN", A_STAT, 16'h0003);

        // R8 bad stop and watchdog
        dev_send(8'h66, 1'b0, 1'b1, 11);
        chk_reg("R8 bad stop dropped", A_STAT, 16'h0003);
        dev_send(8'hFF, 1'b0, 1'b0, 4);
        repeat (300) @(negedge clk);
        dev_send(8'h96, 1'b0, 1'b0, 11);
        chk_reg("R8 clean frame after timeout", A_STAT, 16'h0013);
        chk_reg("R8 byte after timeout", A_RXH, 16'h0096);

        // R3 off wins over on
        bus_write(A_CTRL, 16'h0003);
        dev_send(8'h44, 1'b0, 1'b0, 11);
        chk_reg("R3 off bit wins", A_STAT, 16'h0003);
        bus_write(A_CTRL, 16'h0001);

        // R10/R11 transmit
        send_host(8'h5B);
        chk_reg("R11 TXEMPTY clear while sending", A_STAT, 16'h0001);
        wait_tx(1);
        chk_reg("R11 TXEMPTY after ack", A_STAT, 16'h0003);
        send_host(8'hC3);
        wait_tx(2);

        // R12 NACK
        dev_nack = 1'b1;
        send_host(8'h0F);
        wait_tx(3);
        chk_reg("R12 NACK set", A_STAT, 16'h0103);
        dev_nack = 1'b0;
        send_host(8'h80);
        chk_reg("R12 NACK cleared by write", A_STAT, 16'h0001);
        wait_tx(4);

        // R11 transmitter off holds the byte
        bus_write(A_CTRL, 16'h0200);
        send_host(8'h77);
        repeat (100) @(negedge clk);
        chk("R3 disabled transmitter idle", {31'h0, clk_oe}, 32'h0);
        chk_reg("R11 TXRDY clear while pending", A_STAT, 16'h0000);
        bus_write(A_CTRL, 16'h0100);
        wait_tx(5);
        chk_reg("R11 status after held byte sent", A_STAT, 16'h0003);

        // R13 soft reset
        bus_write(A_IEN, 16'h0010);
        dev_send(8'h21, 1'b0, 1'b0, 11);
        chk_reg("R13 byte pending before reset", A_STAT, 16'h0013);
        bus_write(A_CTRL, 16'h8000);
        chk_reg("R13 status after soft reset", A_STAT, 16'h0003);
        chk_reg("R13 mask after soft reset", A_IMSK, 16'h0000);
        chk_reg("R13 prescale kept", A_PSC, 16'h0014);
        chk("R13 irq low", {31'h0, irq}, 32'h0);
        dev_send(8'h12, 1'b0, 1'b0, 11);
        chk_reg("R13 receiver off after reset", A_STAT, 16'h0003);

        chk("R10 scoreboard drained", tx_exp.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule